// File: doc/BRIEF.md
# Two-Level Nesting Interrupt Arbiter

This block sits between five interrupt sources and a processor core. The five sources are two external lines, two timer overflows and a serial unit whose receive and transmit flags share one request. Software writes two byte-wide registers over a small write-only bus. One register holds a master switch and one enable per source. The other gives each source a high or low level. At each instruction boundary that the core signals, the arbiter looks at the enabled pending sources. It picks one using the level first and a fixed source order second. It then raises a request to the core carrying that source's fixed vector address.

The request and its vector stay unchanged until the core acknowledges. In the acknowledge cycle, the arbiter records that a handler of the winner's level is now running. If the winner is an external or timer source, it also sends that source a one-cycle clear pulse. The serial flags are never cleared by the arbiter. The core reports each handler exit with a return strobe, which retires the highest running level. Together these rules give two-deep nesting: a high-level handler can interrupt a low-level one, and nothing can interrupt a high-level handler.

Top module: `irq_nest_ctrl`

## Requirements
- R1: After reset both registers are zero, no handler level is active, `irq_req` is low, `flag_clr` is zero, and no source is taken at a boundary even with every flag set.
- R2: While the master switch (bit 7 of the enable register) is 0, no request is raised, whatever the individual enable bits hold.
- R3: The enable register gates each source through its own bit: bit 0 external 0, bit 1 timer 0, bit 2 external 1, bit 3 timer 1, bit 4 serial. A pending source whose bit is 0 is never taken.
- R4: The vector for source index i is 0x0003 + 8*i: 0x0003, 0x000B, 0x0013, 0x001B and 0x0023 for indices 0 to 4.
- R5: The level register uses the same bit positions as the enable register, and a 1 means high. A pending high-level source beats every pending low-level source, whatever their order.
- R6: Among pending sources of the same level, the lowest index wins (external 0, timer 0, external 1, timer 1, serial).
- R7: Sources are judged only in a cycle where `insn_done` is 1. `irq_req` rises in the next cycle, and pending flags without that strobe raise nothing.
- R8: Once raised, `irq_req` and `irq_vec` hold their values until a cycle with `irq_ack` high, even if the flags change. `irq_req` is low in the cycle after the acknowledge.
- R9: In the acknowledge cycle, `flag_clr` has exactly bit i set when the winner is source i with i < 4, and is zero for the serial source. The serial request is present when `ser_rx` or `ser_tx` is 1.
- R10: While a high-level handler is active, no request is taken. While only a low-level handler is active, only high-level sources are taken.
- R11: A `reti` pulse clears the high active level if it is set, and otherwise clears the low active level. This restores the nesting state from before the last accepted interrupt.
- R12: A register write with `reg_addr` 0 loads the enable register from `reg_wdata` bits 7 and 4..0. A write with `reg_addr` 1 loads the level register from bits 4..0. Bits 6 and 5 of an enable write and bits 7..5 of a level write have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 selects the enable register, 1 selects the level register |
| reg_wdata | input | 8 | Write data |
| src_flag | input | 4 | Pending flags of external 0, timer 0, external 1, timer 1 |
| ser_rx | input | 1 | Serial receive flag |
| ser_tx | input | 1 | Serial transmit flag |
| insn_done | input | 1 | Instruction-boundary strobe from the core |
| irq_req | output | 1 | Vector request to the core |
| irq_vec | output | VEC_W | Vector address of the held winner |
| irq_ack | input | 1 | Core accepts the held request |
| flag_clr | output | 4 | One-cycle clear pulses to the four non-serial sources |
| reti | input | 1 | Return-from-handler strobe |

## Verification
A corrupted level or enable bit shows up as the wrong vector in the cycle right after the next boundary strobe. A broken nesting state has two visible symptoms: a request appearing during a high-level handler, or a high-level source being refused during a low-level handler. Either one shows at the first boundary after the faulty acknowledge or return. A stale held winner shows up as a vector that changes while the request waits, or as a clear pulse on the wrong source line in the acknowledge cycle. The sweeps cover every flag combination under several level masks and every enable mask. They compare each vector and clear pulse with an arithmetic model.

// File: rtl/irq_nest_ctrl.sv
module irq_nest_ctrl #(
  parameter int VEC_W    = 16,
  parameter int VEC_BASE = 3,
  parameter int VEC_STEP = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic             reg_addr,
  input  logic [7:0]       reg_wdata,
  input  logic [3:0]       src_flag,
  input  logic             ser_rx,
  input  logic             ser_tx,
  input  logic             insn_done,
  output logic             irq_req,
  output logic [VEC_W-1:0] irq_vec,
  input  logic             irq_ack,
  output logic [3:0]       flag_clr,
  input  logic             reti
);
  localparam int NSRC  = 5;
  localparam int IDX_W = $clog2(NSRC);

  logic             ea_q;
  logic [NSRC-1:0]  en_q, hi_q;
  logic             act_hi, act_lo, act_hi_n, act_lo_n;
  logic [IDX_W-1:0] win_q, pick_hi, pick_lo;
  logic             win_hi_q;
  logic [NSRC-1:0]  pend, cand_hi, cand_lo;
  logic             take, accept;

  assign pend    = {ser_rx | ser_tx, src_flag} & en_q & {NSRC{ea_q}};
  assign cand_hi = pend & hi_q & {NSRC{!act_hi}};
  assign cand_lo = pend & ~hi_q & {NSRC{!act_hi && !act_lo}};
  assign take    = insn_done && !irq_req && (|cand_hi || |cand_lo);
  assign accept  = irq_req && irq_ack;

  always_comb begin
    pick_hi = '0;
    pick_lo = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (cand_hi[i]) pick_hi = IDX_W'(i);
      if (cand_lo[i]) pick_lo = IDX_W'(i);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ea_q <= 1'b0;
      en_q <= '0;
      hi_q <= '0;
    end else if (reg_wr) begin
      if (!reg_addr) begin
        ea_q <= reg_wdata[7];
        en_q <= reg_wdata[NSRC-1:0];
      end else begin
        hi_q <= reg_wdata[NSRC-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_req  <= 1'b0;
      win_q    <= '0;
      win_hi_q <= 1'b0;
    end else if (take) begin
      irq_req  <= 1'b1;
      win_q    <= |cand_hi ? pick_hi : pick_lo;
      win_hi_q <= |cand_hi;
    end else if (accept) begin
      irq_req  <= 1'b0;
    end
  end

  always_comb begin
    act_hi_n = act_hi;
    act_lo_n = act_lo;
    if (reti) begin
      if (act_hi) act_hi_n = 1'b0;
      else        act_lo_n = 1'b0;
    end
    if (accept) begin
      if (win_hi_q) act_hi_n = 1'b1;
      else          act_lo_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_hi <= 1'b0;
      act_lo <= 1'b0;
    end else begin
      act_hi <= act_hi_n;
      act_lo <= act_lo_n;
    end
  end

  assign irq_vec = VEC_W'(VEC_BASE + VEC_STEP * int'(win_q));

  for (genvar g = 0; g < 4; g++) begin : g_clr
    assign flag_clr[g] = accept && (win_q == IDX_W'(g));
  end
endmodule

module irq_nest_ctrl_chk #(
  parameter int VEC_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             insn_done,
  input logic             irq_req,
  input logic [VEC_W-1:0] irq_vec,
  input logic             irq_ack,
  input logic [3:0]       flag_clr,
  input logic             reti,
  input logic             ea_q,
  input logic             act_hi,
  input logic             act_lo
);
  p_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_req) |-> $past(ea_q));
  p_boundary_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_req) |-> $past(insn_done));
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req && !irq_ack |=> irq_req && $stable(irq_vec));
  p_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req && irq_ack |=> !irq_req);
  p_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flag_clr != 4'd0 |-> irq_req && irq_ack && $countones(flag_clr) == 1);
  p_hi_block_r10: assert property (@(posedge clk) disable iff (!rst_n)
    act_hi |=> !$rose(irq_req));
  p_reti_hi_r11: assert property (@(posedge clk) disable iff (!rst_n)
    reti && act_hi && !(irq_req && irq_ack) |=> !act_hi);
  p_reti_lo_r11: assert property (@(posedge clk) disable iff (!rst_n)
    reti && !act_hi && !(irq_req && irq_ack) |=> !act_lo);
endmodule

bind irq_nest_ctrl irq_nest_ctrl_chk #(.VEC_W(VEC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .insn_done(insn_done), .irq_req(irq_req),
  .irq_vec(irq_vec), .irq_ack(irq_ack), .flag_clr(flag_clr), .reti(reti),
  .ea_q(ea_q), .act_hi(act_hi), .act_lo(act_lo)
);

// File: tb/irq_nest_ctrl_test.sv
`timescale 1ns/1ps
module irq_nest_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_addr = 1'b0;
  logic [7:0]  reg_wdata = 8'd0;
  logic [3:0]  src_flag = 4'd0;
  logic        ser_rx = 1'b0, ser_tx = 1'b0;
  logic        insn_done = 1'b0, irq_ack = 1'b0, reti = 1'b0;
  logic        irq_req;
  logic [15:0] irq_vec;
  logic [3:0]  flag_clr;

  int checks = 0, errors = 0;
  bit done = 0;
  bit ea_m = 0, ahi_m = 0, alo_m = 0;
  logic [4:0] en_m = '0, pr_m = '0;

  always #2 clk = ~clk;

  irq_nest_ctrl uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .src_flag(src_flag), .ser_rx(ser_rx), .ser_tx(ser_tx),
    .insn_done(insn_done), .irq_req(irq_req), .irq_vec(irq_vec),
    .irq_ack(irq_ack), .flag_clr(flag_clr), .reti(reti)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input bit a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
    if (!a) begin ea_m = d[7]; en_m = d[4:0]; end
    else pr_m = d[4:0];
  endtask

  function automatic int model(input logic [4:0] p);
    if (!ea_m) return -1;
    if (!ahi_m)
      for (int i = 0; i < 5; i++) if (p[i] && en_m[i] && pr_m[i]) return i;
    if (!ahi_m && !alo_m)
      for (int i = 0; i < 5; i++) if (p[i] && en_m[i] && !pr_m[i]) return i;
    return -1;
  endfunction

  task automatic do_reti();
    @(negedge clk);
    reti = 1'b1;
    @(negedge clk);
    reti = 1'b0;
    if (ahi_m) ahi_m = 0; else alo_m = 0;
  endtask

  task automatic trial(input logic [3:0] f, input bit rx, input bit tx,
                       input string tag, input bit ret);
    int e;
    e = model({rx | tx, f});
    @(negedge clk);
    src_flag = f; ser_rx = rx; ser_tx = tx; insn_done = 1'b1;
    @(negedge clk);
    insn_done = 1'b0;
    chk(irq_req == (e >= 0), tag, irq_req, e >= 0);
    if (e >= 0 && irq_req) begin
      chk(irq_vec == 16'(3 + 8 * e), tag, irq_vec, 3 + 8 * e);
      irq_ack = 1'b1;
      #1;
      chk(flag_clr == (e < 4 ? 4'(1 << e) : 4'd0), {tag, " R9"}, flag_clr,
          e < 4 ? (1 << e) : 0);
      @(negedge clk);
      irq_ack = 1'b0;
      chk(irq_req == 1'b0, {tag, " R8"}, irq_req, 0);
      if (pr_m[e]) ahi_m = 1; else alo_m = 1;
      if (ret) do_reti();
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] v0;
    logic [4:0] masks [5];
    masks[0] = 5'h00; masks[1] = 5'h1F; masks[2] = 5'h0A;
    masks[3] = 5'h15; masks[4] = 5'h12;
    repeat (3) @(negedge clk);
    chk(irq_req == 0 && flag_clr == 0, "R1 reset outputs", irq_req, 0);
    rst_n = 1'b1;
    trial(4'hF, 1, 1, "R1 nothing enabled after reset", 1);

    // R2: master switch off
    wr(0, 8'h1F);
    trial(4'hF, 1, 1, "R2 master off", 1);
    wr(0, 8'h7F);
    trial(4'hF, 1, 0, "R2 unused bits do not enable", 1);

    // R7: flags without boundary strobe
    wr(0, 8'h9F);
    @(negedge clk);
    src_flag = 4'h2;
    repeat (3) @(negedge clk);
    chk(irq_req == 0, "R7 no strobe no request", irq_req, 0);

    // R3: every enable mask with all sources pending
    for (int m = 0; m < 32; m++) begin
      wr(0, {3'b100, 5'(m)});
      trial(4'hF, 1, 1, "R3 enable mask", 1);
    end

    // R4 R5 R6 R9: all flag patterns under several level masks
    wr(0, 8'h9F);
    for (int k = 0; k < 5; k++) begin
      wr(1, {3'b000, masks[k]});
      for (int f = 0; f < 64; f++)
        trial(4'(f), f[4], f[5], "R4 R5 R6 sweep", 1);
    end

    // R12: ignored upper bits of level write
    wr(1, 8'hE0);
    trial(4'hF, 0, 0, "R12 level upper bits ignored", 1);
    wr(1, 8'hE2);
    trial(4'hF, 0, 0, "R12 level bit1 high", 1);

    // R8: hold while not acknowledged
    wr(1, 8'h00);
    @(negedge clk);
    src_flag = 4'h8; insn_done = 1'b1;
    @(negedge clk);
    insn_done = 1'b0;
    v0 = irq_vec;
    src_flag = 4'h1;
    repeat (3) @(negedge clk);
    chk(irq_req == 1 && irq_vec == 16'h001B, "R8 held vector", irq_vec, 16'h1B);
    chk(irq_vec == v0, "R8 vector stable", irq_vec, v0);
    irq_ack = 1'b1;
    @(negedge clk);
    irq_ack = 1'b0;
    alo_m = 1;
    do_reti();

    // R10 R11: nesting
    wr(1, 8'h04);
    trial(4'h8, 0, 0, "R10 low taken when idle", 0);
    trial(4'h2, 0, 0, "R10 low blocked by low", 0);
    trial(4'h4, 0, 0, "R10 high preempts low", 0);
    wr(1, 8'h05);
    trial(4'h7, 1, 0, "R10 high blocks all", 0);
    do_reti();
    trial(4'h2, 0, 0, "R11 low still active after one return", 0);
    trial(4'h5, 0, 0, "R11 high allowed after one return", 0);
    do_reti();
    do_reti();
    trial(4'h2, 0, 0, "R11 idle after two returns", 1);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule